// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block sits at the output of a video decoder. It turns a stream of YCbCr 4:2:2 pixels into one of three output formats on two 8-bit ports. Each pixel comes with a luma byte, a chroma byte (Cb and Cr alternate from pixel to pixel), a line-active flag, a vertical-blanking flag, an active-sample flag and a field bit. The block runs on a byte clock at twice the pixel rate. A new pixel is offered on every second cycle and is marked by a one-cycle strobe.

The split format puts luma on port A and chroma on port B in the same cycles, next to separate reference outputs. The two embedded formats interleave chroma and luma onto port A as one byte per clock and carry line timing inside the byte stream:

- The header format uses four-byte start and end markers.
- The code format uses a single marker byte.

In the embedded formats, port B either mirrors port A or holds a programmable static byte. The block looks two pixels ahead, so it can place start markers before a line begins. A format request waits for the next rising vertical-blanking flag before it takes effect.

Top module: `vfmt_top`

## Requirements
- R1: While reset is asserted, both ports and all three reference outputs read zero and the active format is split (format code 00).
- R2: In split format (code 00), a pixel accepted at strobe edge k drives its luma on port A and its chroma on port B after edges k+5 and k+6, unchanged, with no clipping.
- R3: In every format, the line-active, vertical-blanking and active-sample flags of a pixel appear on the reference outputs in the same cycles as that pixel's bytes.
- R4: In the embedded formats (codes 01 and 10), port A emits each pixel as two bytes, chroma after edge k+5 and luma after edge k+6. With Cb/Cr alternating this gives Cb, Y, Cr, Y.
- R5: In header format (code 01), the two pixel slots after a line-active run carry FF,00 then 00,XY with H=1. The two slots before a run carry FF,00 then 00,XY with H=0. XY is, from bit 7 down: 1, F, V, H, V^H, F^H, F^V, F^V^H. F is the slot's field bit and V is its vertical-blanking flag.
- R6: In code format (code 10), the slot just before a line-active run is sent as FF,10 and the slot just after it as 00,10.
- R7: In the embedded formats, active-sample bytes are clipped to 01..FE (00 becomes 01, FF becomes FE).
- R8: In the embedded formats, non-active slots that carry no marker are sent as 80 (chroma byte) and 10 (luma byte).
- R9: In the embedded formats, port B equals port A when the dual-port control is 1. When it is 0, port B shows the spare byte input.
- R10: A new format request becomes active only with the first output pixel whose vertical-blanking flag rises. Until then, the previous format stays in use.
- R11: Format code 11 behaves exactly like split format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_stb | input | 1 | Pixel strobe, high one cycle in two |
| y_in | input | 8 | Luma sample |
| c_in | input | 8 | Chroma sample, Cb/Cr alternating |
| href_in | input | 1 | Line-active reference flag |
| vref_in | input | 1 | Vertical-blanking reference flag |
| vact_in | input | 1 | Active-sample flag |
| field_in | input | 1 | Field bit |
| fmt_sel | input | 2 | Requested output format |
| dual_port | input | 1 | 1: port B mirrors port A in embedded formats |
| spare_val | input | 8 | Static byte for port B in single-port embedded formats |
| port_a | output | 8 | Output port A |
| port_b | output | 8 | Output port B |
| href_out | output | 1 | Line-active reference, aligned to data |
| vref_out | output | 1 | Vertical-blanking reference, aligned to data |
| vact_out | output | 1 | Active-sample reference, aligned to data |

## Verification
On every cycle, the assertions check four things:

- Active bytes in an embedded format never reach 00 or FF.
- Blank slots inside a line carry only blanking levels.
- A header FF is always followed by 00.
- The active format changes only on a shift whose output pixel starts vertical blanking.

Some behaviours can only be shown by the bench's reference model, which predicts every port byte on every clock:

- The exact placement of markers around line runs, and the protection bits of XY.
- The byte order, the mirroring or spare byte on port B, and the deferral of a format request across whole lines.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    parameter int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        FMT_SPLIT = 2'b00,
        FMT_HDR   = 2'b01,
        FMT_CODE  = 2'b10,
        FMT_RSV   = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [DATA_W-1:0] luma;
        logic [DATA_W-1:0] chroma;
        logic              href;
        logic              vblank;
        logic              act;
        logic              fld;
    } pix_t;

endpackage

// File: rtl/vfmt_pipe.sv
// Pixel look-ahead chain, line-flag history, byte phase and format latch.
module vfmt_pipe
    import vfmt_pkg::*;
#(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned HIST  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  pix_t       pix_in,
    input  logic [1:0] fmt_req,
    output pix_t       slot,
    output logic       ahead1_href,
    output logic       ahead2_href,
    output logic       behind1_href,
    output logic       behind2_href,
    output fmt_e       fmt_act,
    output logic       byte_sel
);
    localparam int unsigned OUT_IX = DEPTH - 1;

    typedef struct packed {
        pix_t [DEPTH-1:0] sh;
        logic [HIST-1:0]  hh;
        fmt_e             fmt;
        logic             ph;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = 1'b1;
        if (stb) begin
            st_d.ph = 1'b0;
            st_d.sh = {st_q.sh[DEPTH-2:0], pix_in};
            st_d.hh = {st_q.hh[HIST-2:0], st_q.sh[OUT_IX].href};
            if (st_q.sh[OUT_IX-1].vblank && !st_q.sh[OUT_IX].vblank) begin
                st_d.fmt = fmt_e'(fmt_req);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fmt <= FMT_SPLIT;
            st_q.ph  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot         = st_q.sh[OUT_IX];
    assign ahead1_href  = st_q.sh[OUT_IX-1].href;
    assign ahead2_href  = st_q.sh[OUT_IX-2].href;
    assign behind1_href = st_q.hh[0];
    assign behind2_href = st_q.hh[1];
    assign fmt_act      = st_q.fmt;
    assign byte_sel     = st_q.ph;

    // R10
    fmt_at_vedge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fmt != $past(st_q.fmt)) |->
        $past(stb && st_q.sh[OUT_IX-1].vblank && !st_q.sh[OUT_IX].vblank));

endmodule

// File: rtl/vfmt_embed.sv
// Byte selection for the two embedded formats: markers, clipping, blanking.
module vfmt_embed
    import vfmt_pkg::*;
#(
    parameter logic [DATA_W-1:0] BLANK_Y = 8'h10,
    parameter logic [DATA_W-1:0] BLANK_C = 8'h80,
    parameter logic [DATA_W-1:0] CLIP_LO = 8'h01,
    parameter logic [DATA_W-1:0] CLIP_HI = 8'hFE
) (
    input  pix_t              slot,
    input  logic              ahead1_href,
    input  logic              ahead2_href,
    input  logic              behind1_href,
    input  logic              behind2_href,
    input  logic              hdr_mode,
    input  logic              byte_sel,
    output logic [DATA_W-1:0] emb_byte
);
    localparam logic [DATA_W-1:0] ALL1 = '1;
    localparam logic [DATA_W-1:0] ALL0 = '0;

    logic              eav_a, eav_b, sav_a, sav_b;
    logic [DATA_W-1:0] raw, clipped, xy_eav, xy_sav;

    function automatic logic [7:0] mk_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    always_comb begin
        eav_a  = !slot.href && behind1_href;
        eav_b  = !slot.href && !behind1_href && behind2_href;
        sav_a  = !slot.href && !ahead1_href && ahead2_href;
        sav_b  = !slot.href && ahead1_href;
        xy_eav = mk_xy(slot.fld, slot.vblank, 1'b1);
        xy_sav = mk_xy(slot.fld, slot.vblank, 1'b0);

        raw = byte_sel ? slot.luma : slot.chroma;
        if (raw < CLIP_LO)      clipped = CLIP_LO;
        else if (raw > CLIP_HI) clipped = CLIP_HI;
        else                    clipped = raw;

        if (slot.act) emb_byte = clipped;
        else          emb_byte = byte_sel ? BLANK_Y : BLANK_C;

        if (hdr_mode) begin
            if (eav_a)      emb_byte = byte_sel ? ALL0 : ALL1;
            else if (eav_b) emb_byte = byte_sel ? xy_eav : ALL0;
            else if (sav_a) emb_byte = byte_sel ? ALL0 : ALL1;
            else if (sav_b) emb_byte = byte_sel ? xy_sav : ALL0;
        end else begin
            if (eav_a)      emb_byte = byte_sel ? BLANK_Y : ALL0;
            else if (sav_b) emb_byte = byte_sel ? BLANK_Y : ALL1;
        end
    end

endmodule

// File: rtl/vfmt_top.sv
module vfmt_top
    import vfmt_pkg::*;
#(
    parameter int unsigned      LOOK    = 3,
    parameter logic [DATA_W-1:0] BLANK_Y = 8'h10,
    parameter logic [DATA_W-1:0] BLANK_C = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              px_stb,
    input  logic [DATA_W-1:0] y_in,
    input  logic [DATA_W-1:0] c_in,
    input  logic              href_in,
    input  logic              vref_in,
    input  logic              vact_in,
    input  logic              field_in,
    input  logic [1:0]        fmt_sel,
    input  logic              dual_port,
    input  logic [DATA_W-1:0] spare_val,
    output logic [DATA_W-1:0] port_a,
    output logic [DATA_W-1:0] port_b,
    output logic              href_out,
    output logic              vref_out,
    output logic              vact_out
);
    typedef struct packed {
        logic [DATA_W-1:0] pa;
        logic [DATA_W-1:0] pb;
        logic              hr;
        logic              vr;
        logic              va;
        logic              emb;
        logic              hdr;
    } out_st_t;

    pix_t              pix_in, slot;
    logic              a1, a2, b1, b2, bsel;
    fmt_e              fmt_act;
    logic [DATA_W-1:0] emb_byte;
    logic              split_mode;
    out_st_t           out_d, out_q;

    assign pix_in = '{luma: y_in, chroma: c_in, href: href_in,
                      vblank: vref_in, act: vact_in, fld: field_in};

    vfmt_pipe #(.DEPTH(LOOK), .HIST(2)) pipe_i (
        .clk(clk), .rst_n(rst_n), .stb(px_stb), .pix_in(pix_in),
        .fmt_req(fmt_sel), .slot(slot),
        .ahead1_href(a1), .ahead2_href(a2),
        .behind1_href(b1), .behind2_href(b2),
        .fmt_act(fmt_act), .byte_sel(bsel)
    );

    vfmt_embed #(.BLANK_Y(BLANK_Y), .BLANK_C(BLANK_C)) embed_i (
        .slot(slot), .ahead1_href(a1), .ahead2_href(a2),
        .behind1_href(b1), .behind2_href(b2),
        .hdr_mode(fmt_act == FMT_HDR), .byte_sel(bsel),
        .emb_byte(emb_byte)
    );

    always_comb begin
        split_mode = (fmt_act == FMT_SPLIT) || (fmt_act == FMT_RSV);
        out_d.hr   = slot.href;
        out_d.vr   = slot.vblank;
        out_d.va   = slot.act;
        out_d.emb  = !split_mode;
        out_d.hdr  = (fmt_act == FMT_HDR);
        if (split_mode) begin
            out_d.pa = slot.luma;
            out_d.pb = slot.chroma;
        end else begin
            out_d.pa = emb_byte;
            out_d.pb = dual_port ? emb_byte : spare_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign port_a   = out_q.pa;
    assign port_b   = out_q.pb;
    assign href_out = out_q.hr;
    assign vref_out = out_q.vr;
    assign vact_out = out_q.va;

    // R7
    emb_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.emb && href_out && vact_out) |-> (port_a != '0 && port_a != '1));

    // R8
    emb_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.emb && href_out && !vact_out) |-> (port_a == BLANK_C || port_a == BLANK_Y));

    // R5
    hdr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.hdr && !href_out && port_a == '1) |=> (port_a == '0));

endmodule

// File: tb/vfmt_top_tb_top.sv
module vfmt_top_tb_top;
    localparam int NPIX = 4096;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       px_stb;
    logic [7:0] y_in, c_in, spare_val;
    logic       href_in, vref_in, vact_in, field_in, dual_port;
    logic [1:0] fmt_sel;
    logic [7:0] port_a, port_b;
    logic       href_out, vref_out, vact_out;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    vfmt_top dut_i (
        .clk(clk), .rst_n(rst_n), .px_stb(px_stb), .y_in(y_in), .c_in(c_in),
        .href_in(href_in), .vref_in(vref_in), .vact_in(vact_in),
        .field_in(field_in), .fmt_sel(fmt_sel), .dual_port(dual_port),
        .spare_val(spare_val), .port_a(port_a), .port_b(port_b),
        .href_out(href_out), .vref_out(vref_out), .vact_out(vact_out)
    );

    // reference model storage
    logic [7:0] my [NPIX];
    logic [7:0] mc [NPIX];
    logic       mh [NPIX];
    logic       mv [NPIX];
    logic       ma [NPIX];
    logic       mf [NPIX];
    logic [1:0] mfmt [NPIX];
    int         npix = 0;

    logic [7:0] exp_a, exp_b;
    logic       exp_h, exp_v, exp_x;
    string      tag_a, tag_b;
    logic       exp_valid = 1'b0;

    function automatic logic gh(input int j);
        return (j >= 0 && j < npix) ? mh[j] : 1'b0;
    endfunction

    function automatic logic [1:0] gfmt(input int j);
        return (j >= 0) ? mfmt[j] : 2'b00;
    endfunction

    function automatic logic [7:0] xyv(input logic f, input logic v, input logic h);
        logic [7:0] r;
        r[7] = 1'b1; r[6] = f; r[5] = v; r[4] = h;
        r[3] = v ^ h; r[2] = f ^ h; r[1] = f ^ v; r[0] = f ^ v ^ h;
        return r;
    endfunction

    task automatic model_out(input int j, input int b);
        logic [7:0] yy, cc, d;
        logic       vv, aa, ff;
        logic [1:0] f;
        yy = (j >= 0) ? my[j] : 8'h00;
        cc = (j >= 0) ? mc[j] : 8'h00;
        vv = (j >= 0) ? mv[j] : 1'b0;
        aa = (j >= 0) ? ma[j] : 1'b0;
        ff = (j >= 0) ? mf[j] : 1'b0;
        f  = gfmt(j);
        exp_h = gh(j); exp_v = vv; exp_x = aa;
        if (f == 2'b00 || f == 2'b11) begin
            exp_a = yy; exp_b = cc;
            tag_a = (f == 2'b11) ? "R11" : "R2";
            tag_b = tag_a;
        end else begin
            if (aa) begin
                d = (b == 1) ? yy : cc;
                if (d == 8'h00) begin d = 8'h01; tag_a = "R7"; end
                else if (d == 8'hFF) begin d = 8'hFE; tag_a = "R7"; end
                else tag_a = "R4";
            end else begin
                d = (b == 1) ? 8'h10 : 8'h80;
                tag_a = "R8";
            end
            if (f == 2'b01) begin
                if (!gh(j) && gh(j-1)) begin d = (b == 1) ? 8'h00 : 8'hFF; tag_a = "R5"; end
                else if (!gh(j) && !gh(j-1) && gh(j-2)) begin d = (b == 1) ? xyv(ff, vv, 1'b1) : 8'h00; tag_a = "R5"; end
                else if (!gh(j) && !gh(j+1) && gh(j+2)) begin d = (b == 1) ? 8'h00 : 8'hFF; tag_a = "R5"; end
                else if (!gh(j) && gh(j+1)) begin d = (b == 1) ? xyv(ff, vv, 1'b0) : 8'h00; tag_a = "R5"; end
            end else begin
                if (!gh(j) && gh(j-1)) begin d = (b == 1) ? 8'h10 : 8'h00; tag_a = "R6"; end
                else if (!gh(j) && gh(j+1)) begin d = (b == 1) ? 8'h10 : 8'hFF; tag_a = "R6"; end
            end
            exp_a = d;
            exp_b = dual_port ? d : spare_val;
            tag_b = "R9";
        end
        if (f != fmt_sel) tag_a = "R10";
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            if (px_stb) begin
                int m;
                m = npix;
                my[m] = y_in; mc[m] = c_in; mh[m] = href_in; mv[m] = vref_in;
                ma[m] = vact_in; mf[m] = field_in;
                npix = npix + 1;
                if (m >= 2) begin
                    if (mv[m-2] && !((m >= 3) ? mv[m-3] : 1'b0)) mfmt[m-2] = fmt_sel;
                    else mfmt[m-2] = gfmt(m-3);
                end
                model_out(m - 3, 1);
            end else begin
                model_out(npix - 3, 0);
            end
            exp_valid = 1'b1;
        end
    end

    task automatic chk8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && exp_valid) begin
            chk8(tag_a, "port_a", port_a, exp_a);
            chk8(tag_b, "port_b", port_b, exp_b);
            chk8("R3", "href_out", {7'd0, href_out}, {7'd0, exp_h});
            chk8("R3", "vref_out", {7'd0, vref_out}, {7'd0, exp_v});
            chk8("R3", "vact_out", {7'd0, vact_out}, {7'd0, exp_x});
        end
    end

    task automatic send_pix(input logic [7:0] y, input logic [7:0] c,
                            input logic h, input logic v, input logic a, input logic f);
        px_stb = 1'b1; y_in = y; c_in = c;
        href_in = h; vref_in = v; vact_in = a; field_in = f;
        @(negedge clk);
        px_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_line(input int nact, input logic v, input logic f, input int seed);
        for (int k = 0; k < 6; k++) send_pix(8'h33, 8'hCC, 1'b0, v, 1'b0, f);
        for (int k = 0; k < nact; k++) begin
            logic [7:0] yy, cc;
            yy = 8'((k * 53 + seed) & 255);
            cc = 8'((k * 29 + seed + 7) & 255);
            if (k == 0) yy = 8'hFF;
            if (k == 1) cc = 8'h00;
            if (k == 2) yy = 8'h00;
            if (k == 3) cc = 8'hFF;
            send_pix(yy, cc, 1'b1, v, (k != nact - 2), f);
        end
    endtask

    initial begin
        rst_n = 1'b0; px_stb = 1'b0; y_in = '0; c_in = '0;
        href_in = 1'b0; vref_in = 1'b0; vact_in = 1'b0; field_in = 1'b0;
        fmt_sel = 2'b00; dual_port = 1'b0; spare_val = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        chk8("R1", "port_a", port_a, 8'h00);
        chk8("R1", "port_b", port_b, 8'h00);
        chk8("R1", "refs", {5'd0, href_out, vref_out, vact_out}, 8'h00);
        rst_n = 1'b1;
        send_line(12, 1'b0, 1'b0, 3);
        send_line(10, 1'b0, 1'b0, 17);
        fmt_sel = 2'b01;                      // R10: pending, no vref rise yet
        send_line(10, 1'b0, 1'b0, 41);
        send_line(9, 1'b1, 1'b0, 5);          // vref rises: header format
        send_line(10, 1'b1, 1'b1, 77);
        send_line(12, 1'b0, 1'b1, 90);
        dual_port = 1'b1;
        send_line(10, 1'b0, 1'b0, 120);
        dual_port = 1'b0; spare_val = 8'h3C;
        send_line(8, 1'b0, 1'b1, 200);
        fmt_sel = 2'b10;
        send_line(10, 1'b0, 1'b0, 9);
        send_line(10, 1'b1, 1'b0, 61);        // code format
        send_line(11, 1'b0, 1'b0, 150);
        dual_port = 1'b1;
        send_line(10, 1'b0, 1'b1, 33);
        fmt_sel = 2'b11;
        send_line(10, 1'b1, 1'b0, 18);        // reserved code acts as split
        send_line(10, 1'b0, 1'b0, 222);
        for (int k = 0; k < 6; k++) send_pix(8'h33, 8'hCC, 1'b0, 1'b0, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule